// File: doc/BRIEF.md
# Pixel Clock Source Selector

This block chooses which of several candidate source clocks should feed a display pixel clock, and with which integer divider. A request carries the desired pixel frequency twice, once in Hz and once in kHz, together with the frequency of each candidate source, a present bit per source and a settable bit per source. The block works through the candidates one at a time in ascending index order. For each candidate it computes a rounded divider and the rounded rate that divider would give. It then tests that rate against a tolerance window expressed in thousandths of the target. The first candidate that passes wins. If none passes, the block reports a failure.

All divisions share one multi-cycle restoring divider, so an evaluation takes several hundred cycles. Requests enter on a valid/ready pair. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The result leaves on a second valid/ready pair. `res_valid` rises when the search ends and stays high, with the result fields unchanged, until a clock edge where `res_ready` is high. Only then does the block return to idle. The requester must supply `desired_hz` of at least 1 and `desired_khz` of at least 1.

Top module: `pcs_clock_select`

## Requirements
- R1: Candidates are tried in ascending index order and the lowest-index candidate that qualifies is reported in `sel_idx`. A candidate whose `src_present` bit is 0 is never selected.
- R2: A candidate whose effective rate equals `desired_hz` exactly is selected with `sel_div` = 1.
- R3: Otherwise the divider is floor((rate + floor(desired_hz/2)) / desired_hz), which is rounding to nearest. A divider of 0 or above DIV_MAX rejects that candidate.
- R4: The resulting rate is floor((rate + floor(div/2)) / div), again rounded to nearest.
- R5: When the resulting rate is below `desired_hz`, floor(result / desired_khz) must be at least PM_MIN (default 994). Otherwise the candidate is rejected.
- R6: When the resulting rate is at or above `desired_hz`, ceil(result / desired_khz) must be at most PM_MAX (default 1005). Otherwise the candidate is rejected.
- R7: If no candidate qualifies, the result has `sel_fail` = 1, `sel_idx` = 0 and `sel_div` = 0. A successful result has `sel_fail` = 0.
- R8: `req_ready` is low from the accepted request until the result is taken. `res_valid`, `sel_idx`, `sel_div` and `sel_fail` hold steady while `res_valid` is high and `res_ready` is low.
- R9: After reset, `req_ready` = 1 and `res_valid` = 0.
- R10: For a candidate whose `src_settable` bit is 1, the effective rate is taken to be `desired_hz`, whatever its `src_hz` field says. Such a candidate therefore qualifies with divider 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| desired_hz | input | FW | Target pixel frequency in Hz |
| desired_khz | input | FW | Target pixel frequency in kHz |
| src_hz | input | NSRC*FW | Candidate frequencies; candidate k occupies bits [k*FW +: FW] |
| src_present | input | NSRC | Bit k set when candidate k exists |
| src_settable | input | NSRC | Bit k set when candidate k can be tuned to the target |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| sel_idx | output | $clog2(NSRC+1) | Index of the chosen candidate |
| sel_div | output | $clog2(DIV_MAX+1) | Chosen integer divider |
| sel_fail | output | 1 | No candidate qualified |

## Verification
The bench builds the block with four candidates, 32-bit frequencies, the default 994/1005 window and DIV_MAX lowered to 8. The small divider limit lets a 900 MHz candidate against a 100 MHz target be rejected for a divider of 9, while 800 MHz passes at exactly 8. A target of 1000 Hz with 1 kHz makes the permillage equal to the rounded rate itself. That exposes the effect of rounding both the divider and the rate by a single count. Targets of 100 MHz place window edges such as 99.4 MHz and 100.5 MHz exactly on the limits, one Hz inside or outside them.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_DIVN,
    ST_DIVR,
    ST_DIVP,
    ST_OUT
  } pcs_state_e;
endpackage

// File: rtl/pcs_src_pick.sv
module pcs_src_pick #(
  parameter int NSRC = 4,
  parameter int FW   = 32,
  parameter int IW   = 3
) (
  input  logic [NSRC*FW-1:0] src_hz,
  input  logic [NSRC-1:0]    present,
  input  logic [NSRC-1:0]    settable,
  input  logic [FW-1:0]      desired_hz,
  input  logic [IW-1:0]      idx,
  output logic [FW-1:0]      eff_hz,
  output logic               eff_present,
  output logic               in_range
);
  logic [FW-1:0] rate_arr [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign rate_arr[g] = settable[g] ? desired_hz : src_hz[g*FW +: FW];
  end

  always_comb begin
    eff_hz      = '0;
    eff_present = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (idx == IW'(k)) begin
        eff_hz      = rate_arr[k];
        eff_present = present[k];
      end
    end
  end

  assign in_range = (idx < IW'(NSRC));
endmodule

// File: rtl/pcs_divider.sv
module pcs_divider #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dsr_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [W:0]    shifted, diff;
  logic          ge;

  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, dsr_q};
  assign ge      = ~diff[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start) begin
      rem_q  <= '0;
      quo_q  <= dividend;
      dsr_q  <= divisor;
      cnt_q  <= CW'(W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      rem_q  <= ge ? diff[W-1:0] : shifted[W-1:0];
      quo_q  <= {quo_q[W-2:0], ge};
      cnt_q  <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done     = done_q;
  assign quotient = quo_q;

  // R3 R4: a finished division leaves a remainder below the divisor
  assert_rem_below_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && dsr_q != '0) |-> (rem_q < dsr_q));

  // done is a single-cycle pulse
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/pcs_clock_select.sv
module pcs_clock_select #(
  parameter int NSRC    = 4,
  parameter int FW      = 32,
  parameter int DIV_MAX = 15,
  parameter int PM_MIN  = 994,
  parameter int PM_MAX  = 1005
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [FW-1:0]                desired_hz,
  input  logic [FW-1:0]                desired_khz,
  input  logic [NSRC*FW-1:0]           src_hz,
  input  logic [NSRC-1:0]              src_present,
  input  logic [NSRC-1:0]              src_settable,
  output logic                         res_valid,
  input  logic                         res_ready,
  output logic [$clog2(NSRC+1)-1:0]    sel_idx,
  output logic [$clog2(DIV_MAX+1)-1:0] sel_div,
  output logic                         sel_fail
);
  import pcs_pkg::*;

  localparam int DW  = FW + 1;
  localparam int IW  = $clog2(NSRC + 1);
  localparam int DVW = $clog2(DIV_MAX + 1);

  pcs_state_e          state_q;
  logic [IW-1:0]       idx_q;
  logic [FW-1:0]       des_q, khz_q, real_q;
  logic [NSRC*FW-1:0]  srcs_q;
  logic [NSRC-1:0]     pres_q, sett_q;
  logic [DVW-1:0]      ndiv_q;
  logic                below_q;
  logic [IW-1:0]       out_idx_q;
  logic [DVW-1:0]      out_div_q;
  logic                out_fail_q;

  logic [FW-1:0] eff_hz;
  logic          eff_present, in_range;

  logic          dv_start, dv_done;
  logic [DW-1:0] dv_dividend, dv_divisor, dv_q;

  logic          div_reject, pm_accept;

  pcs_src_pick #(.NSRC(NSRC), .FW(FW), .IW(IW)) u_pick (
    .src_hz      (srcs_q),
    .present     (pres_q),
    .settable    (sett_q),
    .desired_hz  (des_q),
    .idx         (idx_q),
    .eff_hz      (eff_hz),
    .eff_present (eff_present),
    .in_range    (in_range)
  );

  pcs_divider #(.W(DW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (dv_start),
    .dividend (dv_dividend),
    .divisor  (dv_divisor),
    .done     (dv_done),
    .quotient (dv_q)
  );

  assign div_reject = (dv_q == '0) || (dv_q > DW'(DIV_MAX));
  assign pm_accept  = below_q ? (dv_q >= DW'(PM_MIN)) : (dv_q <= DW'(PM_MAX));

  // divider operand steering
  always_comb begin
    dv_start    = 1'b0;
    dv_dividend = '0;
    dv_divisor  = '0;
    unique case (state_q)
      ST_PICK: begin
        if (in_range && eff_present && eff_hz != des_q) begin
          dv_start    = 1'b1;
          dv_dividend = {1'b0, eff_hz} + DW'(des_q >> 1);
          dv_divisor  = {1'b0, des_q};
        end
      end
      ST_DIVN: begin
        if (dv_done && !div_reject) begin
          dv_start    = 1'b1;
          dv_dividend = {1'b0, real_q} + (dv_q >> 1);
          dv_divisor  = dv_q;
        end
      end
      ST_DIVR: begin
        if (dv_done) begin
          dv_start   = 1'b1;
          dv_divisor = {1'b0, khz_q};
          if (dv_q < {1'b0, des_q}) dv_dividend = dv_q;
          else                      dv_dividend = dv_q + {1'b0, khz_q} - DW'(1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      des_q      <= '0;
      khz_q      <= '0;
      real_q     <= '0;
      srcs_q     <= '0;
      pres_q     <= '0;
      sett_q     <= '0;
      ndiv_q     <= '0;
      below_q    <= 1'b0;
      out_idx_q  <= '0;
      out_div_q  <= '0;
      out_fail_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            des_q   <= desired_hz;
            khz_q   <= desired_khz;
            srcs_q  <= src_hz;
            pres_q  <= src_present;
            sett_q  <= src_settable;
            idx_q   <= '0;
            state_q <= ST_PICK;
          end
        end
        ST_PICK: begin
          if (!in_range) begin
            out_idx_q  <= '0;
            out_div_q  <= '0;
            out_fail_q <= 1'b1;
            state_q    <= ST_OUT;
          end else if (!eff_present) begin
            idx_q <= idx_q + IW'(1);
          end else if (eff_hz == des_q) begin
            out_idx_q  <= idx_q;
            out_div_q  <= DVW'(1);
            out_fail_q <= 1'b0;
            state_q    <= ST_OUT;
          end else begin
            real_q  <= eff_hz;
            state_q <= ST_DIVN;
          end
        end
        ST_DIVN: begin
          if (dv_done) begin
            if (div_reject) begin
              idx_q   <= idx_q + IW'(1);
              state_q <= ST_PICK;
            end else begin
              ndiv_q  <= DVW'(dv_q);
              state_q <= ST_DIVR;
            end
          end
        end
        ST_DIVR: begin
          if (dv_done) begin
            below_q <= (dv_q < {1'b0, des_q});
            state_q <= ST_DIVP;
          end
        end
        ST_DIVP: begin
          if (dv_done) begin
            if (pm_accept) begin
              out_idx_q  <= idx_q;
              out_div_q  <= ndiv_q;
              out_fail_q <= 1'b0;
              state_q    <= ST_OUT;
            end else begin
              idx_q   <= idx_q + IW'(1);
              state_q <= ST_PICK;
            end
          end
        end
        ST_OUT: begin
          if (res_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign res_valid = (state_q == ST_OUT);
  assign sel_idx   = out_idx_q;
  assign sel_div   = out_div_q;
  assign sel_fail  = out_fail_q;

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(sel_idx) && $stable(sel_div) && $stable(sel_fail)));

  assert_busy_while_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  assert_div_in_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !sel_fail) |-> (sel_div >= DVW'(1) && sel_div <= DVW'(DIV_MAX)));

  assert_fail_encoding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && sel_fail) |-> (sel_div == '0 && sel_idx == '0));

  assert_idx_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !sel_fail) |-> (sel_idx < IW'(NSRC)));

  assert_start_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dv_start |-> !req_ready);
endmodule

// File: tb/pcs_clock_select_bench.sv
module pcs_clock_select_bench;
  localparam int NSRC = 4;
  localparam int FW   = 32;
  localparam int DMAX = 8;
  localparam int IW   = $clog2(NSRC + 1);
  localparam int DVW  = $clog2(DMAX + 1);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic [FW-1:0]       desired_hz = '0;
  logic [FW-1:0]       desired_khz = '0;
  logic [NSRC*FW-1:0]  src_hz = '0;
  logic [NSRC-1:0]     src_present = '0;
  logic [NSRC-1:0]     src_settable = '0;
  logic                res_valid;
  logic                res_ready = 1'b0;
  logic [IW-1:0]       sel_idx;
  logic [DVW-1:0]      sel_div;
  logic                sel_fail;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pcs_clock_select #(.NSRC(NSRC), .FW(FW), .DIV_MAX(DMAX), .PM_MIN(994), .PM_MAX(1005))
    u_pcs_clock_select (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .desired_hz(desired_hz), .desired_khz(desired_khz), .src_hz(src_hz),
    .src_present(src_present), .src_settable(src_settable),
    .res_valid(res_valid), .res_ready(res_ready),
    .sel_idx(sel_idx), .sel_div(sel_div), .sel_fail(sel_fail));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
      finish_run();
    end
  end

  // One request; checks the result and the handshake
  task automatic run_case(input string tag, input longint des, input longint khz,
                          input longint s0, input longint s1, input longint s2, input longint s3,
                          input logic [3:0] pres, input logic [3:0] sett,
                          input bit exp_fail, input int exp_idx, input int exp_div);
    int waitc;
    logic [IW-1:0] hidx;
    logic [DVW-1:0] hdiv;
    logic hfail;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    desired_hz   = FW'(des);
    desired_khz  = FW'(khz);
    src_hz       = {FW'(s3), FW'(s2), FW'(s1), FW'(s0)};
    src_present  = pres;
    src_settable = sett;
    req_valid    = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // R8: busy once the request is taken
    chk(!req_ready, {tag, " R8 req_ready low while busy"}, longint'(req_ready), 0);
    waitc = 0;
    while (!res_valid && waitc < 5000) begin
      @(negedge clk);
      waitc++;
    end
    chk(res_valid, {tag, " result arrives"}, longint'(res_valid), 1);
    chk(sel_fail == exp_fail, {tag, " fail flag"}, longint'(sel_fail), longint'(exp_fail));
    if (!exp_fail) begin
      chk(sel_idx == IW'(exp_idx), {tag, " index"}, longint'(sel_idx), longint'(exp_idx));
    end else begin
      // R7 failure encoding
      chk(sel_idx == '0, {tag, " R7 index zero"}, longint'(sel_idx), 0);
    end
    chk(sel_div == DVW'(exp_div), {tag, " divider"}, longint'(sel_div), longint'(exp_div));
    // R8 back-pressure: hold for three cycles
    hidx = sel_idx; hdiv = sel_div; hfail = sel_fail;
    repeat (3) @(negedge clk);
    chk(res_valid && sel_idx == hidx && sel_div == hdiv && sel_fail == hfail,
        {tag, " R8 result held"}, longint'(res_valid), 1);
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid && req_ready, {tag, " R8 back to idle"}, longint'(req_ready), 1);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R9 req_ready after reset", longint'(req_ready), 1);
    chk(res_valid == 1'b0, "R9 res_valid after reset", longint'(res_valid), 0);
  endtask

  // R1 R2: two exact matches, lower index wins with divider 1
  task automatic t_exact();
    run_case("R2 exact/R1 priority", 100000000, 100000, 100000000, 100000000, 0, 0,
             4'b0011, 4'b0000, 1'b0, 0, 1);
  endtask

  // R1: absent source 0 would have matched; source 1 at 300 MHz gives div 3
  task automatic t_skip_absent();
    run_case("R1 skip absent", 100000000, 100000, 100000000, 300000000, 0, 0,
             4'b0010, 4'b0000, 1'b0, 1, 3);
  endtask

  // R5: 99 MHz gives 990 (reject); 199500001 Hz gives div 2, 997 (accept)
  task automatic t_below();
    run_case("R5 below window", 100000000, 100000, 99000000, 199500001, 0, 0,
             4'b0011, 4'b0000, 1'b0, 1, 2);
  endtask

  // R6: 100500001 Hz rounds up to 1006 (reject); 100500000 Hz is 1005 (accept)
  task automatic t_upper_edge();
    run_case("R6 upper edge", 100000000, 100000, 100500001, 100500000, 0, 0,
             4'b0011, 4'b0000, 1'b0, 1, 1);
  endtask

  // R5: 99399999 Hz truncates to 993 (reject); 99400000 Hz is 994 (accept)
  task automatic t_lower_edge();
    run_case("R5 lower edge", 100000000, 100000, 99399999, 99400000, 0, 0,
             4'b0011, 4'b0000, 1'b0, 1, 1);
  endtask

  // R3: 900 MHz needs div 9 > 8 (reject); 800 MHz gives div 8
  task automatic t_div_max();
    run_case("R3 divider limit", 100000000, 100000, 900000000, 800000000, 0, 0,
             4'b0011, 4'b0000, 1'b0, 1, 8);
  endtask

  // R3 R10: 40 MHz rounds to div 0 (reject); src1 absent; settable src2 wins with div 1
  task automatic t_div_zero_settable();
    run_case("R3 div zero/R10 settable", 100000000, 100000, 40000000, 100000000, 5, 0,
             4'b0101, 4'b0100, 1'b0, 2, 1);
  endtask

  // R7: every candidate rejected
  task automatic t_all_fail();
    run_case("R7 nothing fits", 100000000, 100000, 40000000, 101000000, 0, 900000000,
             4'b1011, 4'b0000, 1'b1, 0, 0);
  endtask

  // R3: 1990 Hz for 1000 Hz rounds to div 2, rate 995 (accept)
  task automatic t_div_round();
    run_case("R3 round divider", 1000, 1, 1990, 0, 0, 0,
             4'b0001, 4'b0000, 1'b0, 0, 2);
  endtask

  // R4: 2981 Hz, div 3 -> rate rounds to 994 (accept); 2980 Hz -> 993 (reject)
  task automatic t_rate_round();
    run_case("R4 rate rounds up", 1000, 1, 2981, 0, 0, 0,
             4'b0001, 4'b0000, 1'b0, 0, 3);
    run_case("R4 rate rounds down", 1000, 1, 2980, 0, 0, 0,
             4'b0001, 4'b0000, 1'b1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_skip_absent();
    t_below();
    t_upper_edge();
    t_lower_edge();
    t_div_max();
    t_div_zero_settable();
    t_all_fail();
    t_div_round();
    t_rate_round();
    finish_run();
  end
endmodule